// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the control words of a host bridge behind a simple word-oriented CPU bus. It keeps 28 registers of 32 bits at byte offsets 0x00 to 0x6C, one every four bytes. Most of them are plain storage with a defined power-on value. The interrupt enable word cannot be written directly. Software sets bits through one alias and clears bits through another. The interrupt status word shows the live interrupt inputs, masked by that enable word.

One bit of the general configuration word acts as a soft-reset trigger. A write that takes it from 0 to 1 stores the new word and issues a single-cycle system reset request. The block accepts only aligned accesses with all byte lanes enabled. It ignores writes to offsets outside the map and returns zero when those offsets are read. The interrupt inputs pass through a synchronizer of configurable depth before masking.

Top module: `brg_ctl_regfile`

## Requirements
- R1: After reset the registers read 0x00000C40 at 0x00, 0x00001384 at 0x04, 0x2BFF8010 at 0x08, 0x255E0091 at 0x0C, 0x00006140 at 0x10, 0x000001FF at 0x1C and 0x20, 0x00000008 at 0x68, 0x10000000 at 0x6C, and zero at every other mapped offset.
- R2: A write with all four byte enables high to an aligned plain storage offset stores all 32 bits. A read of that offset returns them combinationally in the same cycle.
- R3: A write with any byte enable low, or with byte address bits [1:0] not zero, changes no register.
- R4: A write to the enable-set alias (0x30) ORs the written word into the enable word (0x38).
- R5: A write to the enable-clear alias (0x34) clears every enable bit whose written bit is 1.
- R6: The set alias and the clear alias each read back the last word written to them.
- R7: Writes to the enable word (0x38) and to the status word (0x3C) have no effect.
- R8: A read of 0x3C returns the interrupt input vector ANDed with the enable word. The inputs are delayed by IRQ_SYNC clock edges.
- R9: A write to 0x04 that changes bit 2 from 0 to 1 stores the word and raises sys_rst_req for exactly one cycle, starting at the same edge.
- R10: A write to 0x04 that leaves bit 2 at 1, or writes it as 0, raises no reset request.
- R11: Writes at or above offset 0x70 are ignored, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_be | input | 4 | Byte lane enables; writes need all set |
| bus_addr | input | 8 | Byte address in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data, zero when not a mapped read |
| irq_in | input | 32 | Raw interrupt input vector |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its defaults: an 8-bit address, 28 registers, 32 interrupt inputs, a two-stage synchronizer and bit 2 as the trigger. With the two-stage synchronizer, the test can read the status word in the cycle before a new interrupt vector arrives and again after it has passed through. The 8-bit address reaches past the map, so offsets 0x70 and 0xFC probe the unmapped region. Because the trigger bit resets to 1, the test must first clear it and then set it to produce the reset request. Along the way it checks both kinds of write that must not fire the request.

// File: rtl/brg_pkg.sv
package brg_pkg;

   localparam int BRG_IDX_PON   = 0;
   localparam int BRG_IDX_GEN   = 1;
   localparam int BRG_IDX_IODEV = 2;
   localparam int BRG_IDX_SDRAM = 3;
   localparam int BRG_IDX_MAP   = 4;
   localparam int BRG_IDX_GPDAT = 7;
   localparam int BRG_IDX_GPIE  = 8;
   localparam int BRG_IDX_ENSET = 12;
   localparam int BRG_IDX_ENCLR = 13;
   localparam int BRG_IDX_EN    = 14;
   localparam int BRG_IDX_ISR   = 15;
   localparam int BRG_IDX_DQ    = 26;
   localparam int BRG_IDX_MSIZE = 27;

   typedef enum logic [1:0] {
      SLOT_PLAIN = 2'd0,
      SLOT_TRIG  = 2'd1,
      SLOT_IRQ   = 2'd2
   } brg_slot_e;

   function automatic logic [31:0] brg_reset_word(input int idx);
      case (idx)
         BRG_IDX_PON:   return 32'h0000_0C40;
         BRG_IDX_GEN:   return 32'h0000_1384;
         BRG_IDX_IODEV: return 32'h2BFF_8010;
         BRG_IDX_SDRAM: return 32'h255E_0091;
         BRG_IDX_MAP:   return 32'h0000_6140;
         BRG_IDX_GPDAT: return 32'h0000_01FF;
         BRG_IDX_GPIE:  return 32'h0000_01FF;
         BRG_IDX_DQ:    return 32'h0000_0008;
         BRG_IDX_MSIZE: return 32'h1000_0000;
         default:       return 32'h0000_0000;
      endcase
   endfunction

   function automatic brg_slot_e brg_slot_kind(input int idx);
      if (idx == BRG_IDX_GEN) return SLOT_TRIG;
      if (idx >= BRG_IDX_ENSET && idx <= BRG_IDX_ISR) return SLOT_IRQ;
      return SLOT_PLAIN;
   endfunction

endpackage

// File: rtl/brg_wr_decode.sv
module brg_wr_decode #(
   parameter int ADDR_W   = 8,
   parameter int NUM_REGS = 28,
   parameter int BE_W     = 4
) (
   input  logic                      bus_sel,
   input  logic                      bus_wr,
   input  logic [BE_W-1:0]           bus_be,
   input  logic [ADDR_W-1:0]         bus_addr,
   output logic [NUM_REGS-1:0]       wr_hit,
   output logic                      rd_hit,
   output logic [ADDR_W-3:0]         word_idx
);
   localparam int WORD_W = ADDR_W - 2;

   if (NUM_REGS > (1 << WORD_W)) begin : g_bad_map
      $error("brg_wr_decode: NUM_REGS does not fit in the address window");
   end

   logic full_word;
   logic in_map;
   logic wr_ok;

   assign word_idx  = bus_addr[ADDR_W-1:2];
   assign full_word = (&bus_be) && (bus_addr[1:0] == 2'b00);
   assign in_map    = word_idx < WORD_W'(NUM_REGS);
   assign wr_ok     = bus_sel && bus_wr && full_word && in_map;
   assign rd_hit    = bus_sel && !bus_wr && in_map;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      assign wr_hit[i] = wr_ok && (word_idx == WORD_W'(i));
   end
endmodule

// File: rtl/brg_reg_store.sv
module brg_reg_store
   import brg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 28,
   parameter int TRIG_BIT = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_REGS-1:0]            wr_hit,
   input  logic [DATA_W-1:0]              wdata,
   output logic [NUM_REGS-1:0][DATA_W-1:0] word_q,
   output logic                           rst_req,
   output logic                           trig_level
);
   if (TRIG_BIT >= DATA_W) begin : g_bad_trig
      $error("brg_reg_store: TRIG_BIT outside the data word");
   end

   logic [NUM_REGS-1:0] req_vec;
   logic [NUM_REGS-1:0] lvl_vec;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(brg_reset_word(i));
      if (brg_slot_kind(i) == SLOT_IRQ) begin : g_irq
         assign word_q[i]  = '0;
         assign req_vec[i] = 1'b0;
         assign lvl_vec[i] = 1'b0;
      end else if (brg_slot_kind(i) == SLOT_TRIG) begin : g_trig
         logic [DATA_W-1:0] q;
         logic              pulse;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q     <= RST_VAL;
               pulse <= 1'b0;
            end else begin
               pulse <= 1'b0;
               if (wr_hit[i]) begin
                  q     <= wdata;
                  pulse <= !q[TRIG_BIT] && wdata[TRIG_BIT];
               end
            end
         end
         assign word_q[i]  = q;
         assign req_vec[i] = pulse;
         assign lvl_vec[i] = q[TRIG_BIT];
      end else begin : g_plain
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= RST_VAL;
            else if (wr_hit[i]) q <= wdata;
         end
         assign word_q[i]  = q;
         assign req_vec[i] = 1'b0;
         assign lvl_vec[i] = 1'b0;
      end
   end

   assign rst_req    = |req_vec;
   assign trig_level = |lvl_vec;
endmodule

// File: rtl/brg_irq_en.sv
module brg_irq_en #(
   parameter int DATA_W   = 32,
   parameter int IRQ_W    = 32,
   parameter int IRQ_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_wr,
   input  logic              clr_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IRQ_W-1:0]  irq_in,
   output logic [DATA_W-1:0] en_q,
   output logic [DATA_W-1:0] set_q,
   output logic [DATA_W-1:0] clr_q,
   output logic [DATA_W-1:0] status
);
   if (IRQ_W > DATA_W || IRQ_W < 1) begin : g_bad_irq
      $error("brg_irq_en: IRQ_W must be 1..DATA_W");
   end

   logic [IRQ_W-1:0] irq_s;

   if (IRQ_SYNC == 0) begin : g_nosync
      assign irq_s = irq_in;
   end else begin : g_sync
      logic [IRQ_SYNC-1:0][IRQ_W-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe <= '0;
         end else begin
            pipe[0] <= irq_in;
            for (int k = 1; k < IRQ_SYNC; k++) pipe[k] <= pipe[k-1];
         end
      end
      assign irq_s = pipe[IRQ_SYNC-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         set_q <= '0;
         clr_q <= '0;
      end else if (set_wr) begin
         set_q <= wdata;
         en_q  <= en_q | wdata;
      end else if (clr_wr) begin
         clr_q <= wdata;
         en_q  <= en_q & ~wdata;
      end
   end

   assign status = DATA_W'(irq_s) & en_q;
endmodule

// File: rtl/brg_ctl_regfile.sv
module brg_ctl_regfile
   import brg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int NUM_REGS = 28,
   parameter int IRQ_W    = 32,
   parameter int IRQ_SYNC = 2,
   parameter int TRIG_BIT = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [DATA_W/8-1:0]  bus_be,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [IRQ_W-1:0]     irq_in,
   output logic                 sys_rst_req
);
   localparam int BE_W   = DATA_W / 8;
   localparam int WORD_W = ADDR_W - 2;

   if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_dw
      $error("brg_ctl_regfile: DATA_W must be a byte multiple of at least 32");
   end
   if (NUM_REGS <= BRG_IDX_MSIZE) begin : g_bad_nr
      $error("brg_ctl_regfile: NUM_REGS must cover all defined slots");
   end
   if (IRQ_SYNC < 0) begin : g_bad_sync
      $error("brg_ctl_regfile: IRQ_SYNC must not be negative");
   end

   logic [NUM_REGS-1:0]             wr_hit;
   logic                            rd_hit;
   logic [WORD_W-1:0]               word_idx;
   logic [NUM_REGS-1:0][DATA_W-1:0] store_q;
   logic                            trig_level;
   logic [DATA_W-1:0]               en_q;
   logic [DATA_W-1:0]               set_q;
   logic [DATA_W-1:0]               clr_q;
   logic [DATA_W-1:0]               status;

   brg_wr_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .BE_W     (BE_W)
   ) u_dec (
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_be   (bus_be),
      .bus_addr (bus_addr),
      .wr_hit   (wr_hit),
      .rd_hit   (rd_hit),
      .word_idx (word_idx)
   );

   brg_reg_store #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .TRIG_BIT (TRIG_BIT)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit     (wr_hit),
      .wdata      (bus_wdata),
      .word_q     (store_q),
      .rst_req    (sys_rst_req),
      .trig_level (trig_level)
   );

   brg_irq_en #(
      .DATA_W   (DATA_W),
      .IRQ_W    (IRQ_W),
      .IRQ_SYNC (IRQ_SYNC)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_wr (wr_hit[BRG_IDX_ENSET]),
      .clr_wr (wr_hit[BRG_IDX_ENCLR]),
      .wdata  (bus_wdata),
      .irq_in (irq_in),
      .en_q   (en_q),
      .set_q  (set_q),
      .clr_q  (clr_q),
      .status (status)
   );

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (word_idx == WORD_W'(i)) begin
               case (i)
                  BRG_IDX_ENSET: bus_rdata = set_q;
                  BRG_IDX_ENCLR: bus_rdata = clr_q;
                  BRG_IDX_EN:    bus_rdata = en_q;
                  BRG_IDX_ISR:   bus_rdata = status;
                  default:       bus_rdata = store_q[i];
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/brg_ctl_regfile_chk.sv
module brg_ctl_regfile_chk
   import brg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int NUM_REGS = 28
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel,
   input logic                bus_wr,
   input logic [DATA_W/8-1:0] bus_be,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [DATA_W-1:0]   en_q,
   input logic                trig_level,
   input logic                sys_rst_req
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] w;
   logic              full_wr;
   assign w       = bus_addr[ADDR_W-1:2];
   assign full_wr = bus_sel && bus_wr && (&bus_be) && (bus_addr[1:0] == 2'b00);

   assert_enset_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full_wr && w == WORD_W'(BRG_IDX_ENSET))
      |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

   assert_enclr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (full_wr && w == WORD_W'(BRG_IDX_ENCLR))
      |=> ((en_q & $past(bus_wdata)) == '0));

   assert_ro_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full_wr && (w == WORD_W'(BRG_IDX_EN) || w == WORD_W'(BRG_IDX_ISR)))
      |=> $stable(en_q));

   assert_partial_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !full_wr) |=> ($stable(en_q) && $stable(trig_level)));

   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |=> !sys_rst_req);

   assert_pulse_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> (trig_level && !$past(trig_level)));

   assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && w >= WORD_W'(NUM_REGS)) |-> (bus_rdata == '0));
endmodule

bind brg_ctl_regfile brg_ctl_regfile_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_be      (bus_be),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .en_q        (en_q),
   .trig_level  (trig_level),
   .sys_rst_req (sys_rst_req)
);

// File: tb/brg_ctl_regfile_tb.sv
module brg_ctl_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_be = 4'h0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [31:0] irq_in = 32'h0;
   logic        sys_rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   brg_ctl_regfile u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_wr      (bus_wr),
      .bus_be      (bus_be),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .irq_in      (irq_in),
      .sys_rst_req (sys_rst_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 4'hF;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0; bus_be = 4'h0;
   endtask

   task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic t_reset();
      rd_check("R1", 8'h00, 32'h0000_0C40);
      rd_check("R1", 8'h04, 32'h0000_1384);
      rd_check("R1", 8'h08, 32'h2BFF_8010);
      rd_check("R1", 8'h0C, 32'h255E_0091);
      rd_check("R1", 8'h10, 32'h0000_6140);
      rd_check("R1", 8'h1C, 32'h0000_01FF);
      rd_check("R1", 8'h20, 32'h0000_01FF);
      rd_check("R1", 8'h68, 32'h0000_0008);
      rd_check("R1", 8'h6C, 32'h1000_0000);
      rd_check("R1", 8'h14, 32'h0);
      rd_check("R1", 8'h38, 32'h0);
      check("R9 idle after reset", {31'h0, sys_rst_req}, 32'h0);
   endtask

   task automatic t_plain();
      wr(8'h14, 32'hDEAD_BEEF);
      rd_check("R2", 8'h14, 32'hDEAD_BEEF);
      wr(8'h40, 32'h1234_5678);
      rd_check("R2", 8'h40, 32'h1234_5678);
      wr(8'h6C, 32'h0800_0000);
      rd_check("R2", 8'h6C, 32'h0800_0000);
   endtask

   task automatic t_partial();
      wr(8'h14, 32'h1111_1111, 4'b0011);
      rd_check("R3 partial lanes", 8'h14, 32'hDEAD_BEEF);
      wr(8'h16, 32'h2222_2222);
      rd_check("R3 misaligned", 8'h14, 32'hDEAD_BEEF);
      wr(8'h30, 32'hFFFF_FFFF, 4'b1110);
      rd_check("R3 partial set alias", 8'h38, 32'h0);
   endtask

   task automatic t_enable();
      wr(8'h30, 32'h0000_00F0);
      rd_check("R4", 8'h38, 32'h0000_00F0);
      rd_check("R6 set readback", 8'h30, 32'h0000_00F0);
      wr(8'h30, 32'h0000_0F00);
      rd_check("R4 accumulates", 8'h38, 32'h0000_0FF0);
      wr(8'h34, 32'h0000_0030);
      rd_check("R5", 8'h38, 32'h0000_0FC0);
      rd_check("R6 clr readback", 8'h34, 32'h0000_0030);
      rd_check("R6 set kept", 8'h30, 32'h0000_0F00);
   endtask

   task automatic t_readonly();
      wr(8'h38, 32'hFFFF_FFFF);
      rd_check("R7 enable write", 8'h38, 32'h0000_0FC0);
      wr(8'h3C, 32'hFFFF_FFFF);
      rd_check("R7 status write", 8'h38, 32'h0000_0FC0);
      rd_check("R7 status value", 8'h3C, 32'h0);
   endtask

   task automatic t_status();
      @(negedge clk);
      irq_in = 32'hFFFF_FFFF;
      rd_check("R8 before sync", 8'h3C, 32'h0);
      @(negedge clk);
      rd_check("R8 one edge", 8'h3C, 32'h0);
      @(negedge clk);
      rd_check("R8 masked", 8'h3C, 32'h0000_0FC0);
      irq_in = 32'h8000_0440;
      @(negedge clk);
      @(negedge clk);
      rd_check("R8 pattern", 8'h3C, 32'h0000_0440);
      irq_in = 32'h0;
      @(negedge clk);
      @(negedge clk);
      rd_check("R8 cleared", 8'h3C, 32'h0);
   endtask

   task automatic t_softrst();
      wr(8'h04, 32'h0000_1384);
      check("R10 one to one", {31'h0, sys_rst_req}, 32'h0);
      wr(8'h04, 32'h0000_1380);
      check("R10 write zero", {31'h0, sys_rst_req}, 32'h0);
      wr(8'h04, 32'h0000_0005);
      check("R9 pulse", {31'h0, sys_rst_req}, 32'h1);
      @(negedge clk);
      check("R9 one cycle", {31'h0, sys_rst_req}, 32'h0);
      rd_check("R9 stored", 8'h04, 32'h0000_0005);
      wr(8'h04, 32'h0000_0007);
      check("R10 stays set", {31'h0, sys_rst_req}, 32'h0);
   endtask

   task automatic t_unmapped();
      wr(8'h70, 32'hAAAA_5555);
      rd_check("R11 read 0x70", 8'h70, 32'h0);
      rd_check("R11 read 0xFC", 8'hFC, 32'h0);
      rd_check("R11 no alias", 8'h00, 32'h0000_0C40);
      rd_check("R11 no alias", 8'h6C, 32'h0800_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_partial();
      t_enable();
      t_readonly();
      t_status();
      t_softrst();
      t_unmapped();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule